// File: doc/BRIEF.md
# DDR2 Command Timing Guard

This block stands between a memory command scheduler and the DRAM command bus. It holds one programmable register of timing fields, and it grants a requested command only after every delay that applies to that command has elapsed. The delays are measured from earlier events: a clock-enable rising edge, a granted read, a granted precharge-all, and the most recent activates.

The scheduler raises `req_valid` with a command code and keeps both steady until `grant` is seen high in the same cycle. The block never drops a request. It only holds the grant low. A clock-enable exit event is reported on `cke_rise`, and `cke_slow` selects which exit delay applies. The timing register is written through a simple write port. Those writes are ignored while the write-protect input is high, and the current contents can always be read back.

Top module: `cmd_timing_guard`

## Requirements
- R1: With `cke_rise`=1 and `cke_slow`=0 in cycle t, a read (code 2) is not granted in cycle t and not before cycle t+D+1, where D is field bits [3:0]. It is granted in cycle t+D+1 if no other rule holds it. Reset value of D is 2.
- R2: With `cke_rise`=1 and `cke_slow`=1 in cycle t, the same rule as R1 applies, but with D taken from field bits [7:4]. Reset value is 6.
- R3: After a precharge-all (code 4) is granted in cycle t, no command of any code is granted before cycle t+D+1, where D is bits [11:8]. Reset value is 0.
- R4: After a read is granted in cycle t, neither a precharge (code 3) nor a precharge-all is granted before cycle t+D+1, where D is bits [14:12]. Reset value is 2.
- R5: With `eight_bank`=1 and window W in bits [19:16] (reset value 4), an activate (code 1) in cycle t is granted only if fewer than four activates were granted in cycles t-W+1 through t-1. Otherwise it is held until that becomes true.
- R6: With `eight_bank`=0, activates are never held by the four-activate window.
- R7: A write with `cfg_we`=1 while `cfg_wp`=1 leaves the register unchanged. With `cfg_wp`=0, the register takes `cfg_wdata` at the next clock edge.
- R8: `cfg_rdata` always shows the current fields at the bit positions given in R1 to R5, whatever the state of `cfg_wp`. Bit 15 always reads 0. After reset the register reads 0x42062.
- R9: `grant` is combinational in the request cycle. It is never high without `req_valid`. A command that several rules hold is granted only after all of them have expired. Codes other than 1 to 4 are limited only by R3.
- R10: A delay field of zero lets the dependent command be granted in the cycle right after the triggering event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request present |
| req_cmd | input | 3 | Command code: 1 activate, 2 read, 3 precharge, 4 precharge-all, others generic |
| grant | output | 1 | Request may issue in this cycle |
| cke_rise | input | 1 | Clock enable rose in this cycle (power-down exit) |
| cke_slow | input | 1 | Exit is of the slow kind when high |
| eight_bank | input | 1 | Device has eight banks; enables the four-activate window |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wp | input | 1 | Write protect; writes ignored while high |
| cfg_wdata | input | 20 | Timing register write data |
| cfg_rdata | output | 20 | Timing register contents |

## Verification
Each delay rule is driven by holding a request steady after its triggering event and recording the first cycle in which it is granted. This separates an off-by-one in the counter load from an off-by-one in the release. The four-activate window uses a window of eight and a burst of back-to-back activates. The bench checks the stall on the fifth activate, the release exactly eight cycles after the first, and a second stall once four newer activates have filled the history. This shows that the history shifts rather than resets. Overlapping precharge-all and power-down-exit delays show that the grant waits for the longer of the two. The zero-delay settings, and the run with `eight_bank` low, show that the rules disappear cleanly.

// File: rtl/ctg_pkg.sv
package ctg_pkg;

  localparam int CFG_W  = 20;
  localparam int XP_W   = 4;
  localparam int PREA_W = 4;
  localparam int RTP_W  = 3;
  localparam int FAW_W  = 4;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_PRE   = 3'd3,
    CMD_PREA  = 3'd4,
    CMD_OTHER = 3'd5
  } cmd_e;

  typedef struct packed {
    logic [FAW_W-1:0]  faw;
    logic [RTP_W-1:0]  rtp;
    logic [PREA_W-1:0] prea;
    logic [XP_W-1:0]   xp_slow;
    logic [XP_W-1:0]   xp_fast;
  } timing_cfg_t;

  localparam timing_cfg_t CFG_RESET = '{
    faw: 4'd4, rtp: 3'd2, prea: 4'd0, xp_slow: 4'd6, xp_fast: 4'd2
  };

  // register image: faw[19:16], spare[15], rtp[14:12], prea[11:8], slow[7:4], fast[3:0]
  function automatic logic [CFG_W-1:0] pack_cfg(input timing_cfg_t c);
    return {c.faw, 1'b0, c.rtp, c.prea, c.xp_slow, c.xp_fast};
  endfunction

  function automatic timing_cfg_t unpack_cfg(input logic [CFG_W-1:0] d);
    timing_cfg_t c;
    c.faw     = d[19:16];
    c.rtp     = d[14:12];
    c.prea    = d[11:8];
    c.xp_slow = d[7:4];
    c.xp_fast = d[3:0];
    return c;
  endfunction

  // saturating increment used for activate ages
  function automatic logic [FAW_W:0] age_step(input logic [FAW_W:0] a);
    return (a == '1) ? a : a + 1'b1;
  endfunction

endpackage

// File: rtl/ctg_param_reg.sv
module ctg_param_reg
  import ctg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_protect,
  input  logic [CFG_W-1:0] wr_data,
  output timing_cfg_t      cfg,
  output logic [CFG_W-1:0] rd_data
);

  logic wr_accept;
  logic spare_bit;

  assign wr_accept = wr_en && !wr_protect;
  assign spare_bit = wr_data[15];

  always_ff @(posedge clk) begin
    if (!rst_n)         cfg <= CFG_RESET;
    else if (wr_accept) cfg <= unpack_cfg(wr_data);
  end

  assign rd_data = pack_cfg(cfg);

  p_protect_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_protect) |=> $stable(rd_data));

  p_spare_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && spare_bit) |=> (rd_data[15] == 1'b0));

endmodule

// File: rtl/ctg_delay_timer.sv
module ctg_delay_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  p_timer_drains_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !busy);

endmodule

// File: rtl/ctg_act_window.sv
module ctg_act_window
  import ctg_pkg::*;
#(
  parameter int LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             act_fire,
  input  logic [FAW_W-1:0] window,
  output logic             allow
);

  localparam int AGE_W = FAW_W + 1;

  logic [AGE_W-1:0] age [LIMIT];
  logic [LIMIT-1:0] vld;
  logic [LIMIT-1:0] recent;
  logic [AGE_W-1:0] win_ext;

  assign win_ext = {1'b0, window};

  generate
    for (genvar i = 0; i < LIMIT; i++) begin : g_slot
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            age[i] <= '0;
            vld[i] <= 1'b0;
          end else if (act_fire) begin
            age[i] <= AGE_W'(1);
            vld[i] <= 1'b1;
          end else begin
            age[i] <= age_step(age[i]);
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            age[i] <= '0;
            vld[i] <= 1'b0;
          end else if (act_fire) begin
            age[i] <= age_step(age[i-1]);
            vld[i] <= vld[i-1];
          end else begin
            age[i] <= age_step(age[i]);
          end
        end
      end
      assign recent[i] = vld[i] && (age[i] < win_ext);
    end
  endgenerate

  assign allow = !enable || !vld[LIMIT-1] || (age[LIMIT-1] >= win_ext);

  p_act_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fire && enable) |-> ($countones(recent) < LIMIT));

endmodule

// File: rtl/cmd_timing_guard.sv
module cmd_timing_guard
  import ctg_pkg::*;
#(
  parameter int ACT_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  output logic             grant,
  input  logic             cke_rise,
  input  logic             cke_slow,
  input  logic             eight_bank,
  input  logic             cfg_we,
  input  logic             cfg_wp,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata
);

  timing_cfg_t cfg;
  cmd_e        cmd;
  logic        xp_busy, prea_busy, rtp_busy, faw_allow;
  logic        xp_block, cmd_ok;
  logic        act_fire, rd_fire, pre_fire, prea_fire;
  logic [XP_W-1:0] xp_load_val;

  assign cmd = cmd_e'(req_cmd);

  ctg_param_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_protect(cfg_wp),
    .wr_data(cfg_wdata), .cfg(cfg), .rd_data(cfg_rdata)
  );

  assign xp_load_val = cke_slow ? cfg.xp_slow : cfg.xp_fast;

  ctg_delay_timer #(.W(XP_W)) u_xp (
    .clk(clk), .rst_n(rst_n), .load(cke_rise), .load_val(xp_load_val), .busy(xp_busy)
  );

  ctg_delay_timer #(.W(PREA_W)) u_prea (
    .clk(clk), .rst_n(rst_n), .load(prea_fire), .load_val(cfg.prea), .busy(prea_busy)
  );

  ctg_delay_timer #(.W(RTP_W)) u_rtp (
    .clk(clk), .rst_n(rst_n), .load(rd_fire), .load_val(cfg.rtp), .busy(rtp_busy)
  );

  ctg_act_window #(.LIMIT(ACT_LIMIT)) u_faw (
    .clk(clk), .rst_n(rst_n), .enable(eight_bank), .act_fire(act_fire),
    .window(cfg.faw), .allow(faw_allow)
  );

  // a read may not share the cycle of the exit event itself
  assign xp_block = xp_busy || cke_rise;

  always_comb begin
    unique case (cmd)
      CMD_ACT:  cmd_ok = !prea_busy && faw_allow;
      CMD_RD:   cmd_ok = !prea_busy && !xp_block;
      CMD_PRE:  cmd_ok = !prea_busy && !rtp_busy;
      CMD_PREA: cmd_ok = !prea_busy && !rtp_busy;
      default:  cmd_ok = !prea_busy;
    endcase
  end

  assign grant     = req_valid && cmd_ok;
  assign act_fire  = grant && (cmd == CMD_ACT);
  assign rd_fire   = grant && (cmd == CMD_RD);
  assign pre_fire  = grant && (cmd == CMD_PRE);
  assign prea_fire = grant && (cmd == CMD_PREA);

  p_exit_same_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cke_rise |-> !rd_fire);

  p_fast_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_rise && !cke_slow && cfg.xp_fast != '0) |=> !rd_fire);

  p_slow_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_rise && cke_slow && cfg.xp_slow != '0) |=> !rd_fire);

  p_prea_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prea_fire && cfg.prea != '0) |=> !grant);

  p_rd_to_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && cfg.rtp != '0) |=> !(pre_fire || prea_fire));

  p_one_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_fire, rd_fire, pre_fire, prea_fire}));

endmodule

// File: tb/tb_cmd_timing_guard.sv
module tb_cmd_timing_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cmd = 3'd0;
  logic        grant;
  logic        cke_rise = 1'b0, cke_slow = 1'b0, eight_bank = 1'b0;
  logic        cfg_we = 1'b0, cfg_wp = 1'b0;
  logic [19:0] cfg_wdata = '0;
  logic [19:0] cfg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] ACT = 3'd1, RD = 3'd2, PRE = 3'd3, PREA = 3'd4, OTH = 3'd5;
  localparam logic [19:0] DEF = 20'h42062;

  always #2.5 clk = ~clk;

  cmd_timing_guard dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .grant(grant),
    .cke_rise(cke_rise), .cke_slow(cke_slow), .eight_bank(eight_bank),
    .cfg_we(cfg_we), .cfg_wp(cfg_wp), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input logic [19:0] got, input logic [19:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [2:0] c, input logic ck, input logic sl,
                     input logic exp, input string tag);
    @(negedge clk);
    req_valid = v; req_cmd = c; cke_rise = ck; cke_slow = sl;
    #1;
    check({19'd0, grant}, {19'd0, exp}, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R9 idle");
  endtask

  task automatic wr(input logic [19:0] d, input logic wp);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d; cfg_wp = wp;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    check(cfg_rdata, DEF, "R8 reset value");
    cyc(1'b0, RD, 1'b0, 1'b0, 1'b0, "R9 no grant without request");
  endtask

  task automatic t_protect;
    wr(20'hFFFFF, 1'b1);
    check(cfg_rdata, DEF, "R7 protected write ignored");
    check(cfg_rdata, DEF, "R8 readback while protected");
    cfg_wp = 1'b0;
    wr(20'hFFFFF, 1'b0);
    check(cfg_rdata, 20'hF7FFF, "R8 spare bit reads zero");
    wr(DEF, 1'b0);
    check(cfg_rdata, DEF, "R7 unprotected write applies");
  endtask

  task automatic t_slow_exit;
    cyc(1'b0, RD, 1'b1, 1'b1, 1'b0, "R2 exit event");
    for (int i = 0; i < 6; i++) cyc(1'b1, RD, 1'b0, 1'b0, 1'b0, "R2 read held");
    cyc(1'b1, RD, 1'b0, 1'b0, 1'b1, "R2 read released");
    idle(20);
  endtask

  task automatic t_fast_exit;
    wr(20'h42063, 1'b0);
    cyc(1'b1, RD, 1'b1, 1'b0, 1'b0, "R1 read in exit cycle");
    for (int i = 0; i < 3; i++) cyc(1'b1, RD, 1'b0, 1'b0, 1'b0, "R1 read held");
    cyc(1'b1, RD, 1'b0, 1'b0, 1'b1, "R1 read released");
    idle(20);
    wr(DEF, 1'b0);
  endtask

  task automatic t_rd_to_pre;
    cyc(1'b1, RD, 1'b0, 1'b0, 1'b1, "R4 read");
    for (int i = 0; i < 2; i++) cyc(1'b1, PRE, 1'b0, 1'b0, 1'b0, "R4 precharge held");
    cyc(1'b1, PRE, 1'b0, 1'b0, 1'b1, "R4 precharge released");
    idle(10);
    cyc(1'b1, RD, 1'b0, 1'b0, 1'b1, "R4 read");
    for (int i = 0; i < 2; i++) cyc(1'b1, PREA, 1'b0, 1'b0, 1'b0, "R4 precharge-all held");
    cyc(1'b1, PREA, 1'b0, 1'b0, 1'b1, "R4 precharge-all released");
    idle(20);
  endtask

  task automatic t_prea;
    wr(20'h42362, 1'b0);
    cyc(1'b1, PREA, 1'b0, 1'b0, 1'b1, "R3 precharge-all");
    cyc(1'b1, OTH, 1'b0, 1'b0, 1'b0, "R3 other held");
    cyc(1'b1, ACT, 1'b0, 1'b0, 1'b0, "R3 activate held");
    cyc(1'b1, RD,  1'b0, 1'b0, 1'b0, "R3 read held");
    cyc(1'b1, OTH, 1'b0, 1'b0, 1'b1, "R3 other released");
    idle(20);
    wr(DEF, 1'b0);
  endtask

  task automatic t_zero;
    wr(20'h40000, 1'b0);
    cyc(1'b0, RD,  1'b1, 1'b0, 1'b0, "R10 exit event");
    cyc(1'b1, RD,  1'b0, 1'b0, 1'b1, "R10 read next cycle");
    cyc(1'b1, PRE, 1'b0, 1'b0, 1'b1, "R10 precharge next cycle");
    cyc(1'b1, PREA, 1'b0, 1'b0, 1'b1, "R10 precharge-all");
    cyc(1'b1, ACT, 1'b0, 1'b0, 1'b1, "R10 activate next cycle");
    idle(20);
    wr(DEF, 1'b0);
  endtask

  task automatic t_faw;
    eight_bank = 1'b1;
    wr(20'h82062, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b1, ACT, 1'b0, 1'b0, 1'b1, "R5 first four");
    for (int i = 0; i < 4; i++) cyc(1'b1, ACT, 1'b0, 1'b0, 1'b0, "R5 fifth held");
    for (int i = 0; i < 4; i++) cyc(1'b1, ACT, 1'b0, 1'b0, 1'b1, "R5 window slides");
    cyc(1'b1, ACT, 1'b0, 1'b0, 1'b0, "R5 history refilled");
    idle(20);
  endtask

  task automatic t_no_limit;
    eight_bank = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b1, ACT, 1'b0, 1'b0, 1'b1, "R6 unlimited activates");
    idle(20);
    wr(DEF, 1'b0);
  endtask

  task automatic t_multi;
    wr(20'h42265, 1'b0);
    cyc(1'b1, PREA, 1'b1, 1'b0, 1'b1, "R9 precharge-all with exit");
    cyc(1'b0, RD, 1'b0, 1'b0, 1'b0, "R9 no request");
    for (int i = 0; i < 4; i++) cyc(1'b1, RD, 1'b0, 1'b0, 1'b0, "R9 read held by both");
    cyc(1'b1, RD, 1'b0, 1'b0, 1'b1, "R9 read after longest");
    idle(20);
    wr(DEF, 1'b0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_protect();
    t_slow_exit();
    t_fast_exit();
    t_rd_to_pre();
    t_prea();
    t_zero();
    t_faw();
    t_no_limit();
    t_multi();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finished");
      summary();
      $finish;
    end
  end

endmodule